// File: doc/BRIEF.md
# SPI-attached UART link controller

This block runs an external UART that sits on an SPI bus. Every exchange with the UART is one full-duplex 16-bit frame. After reset the controller programs the UART with a configuration word that carries a baud code. It reads the configuration back and repeats the write until the returned baud code matches. Only then does it declare the link ready.

Once ready, the controller turns each byte offered on a valid/ready port into a transmit command. It can fold a request-to-send flag into that command. When the UART pulls its active-low interrupt line down, the controller fetches the waiting byte with an all-zero frame. It presents that byte for one cycle and updates a clear-to-send flag taken from the same frame. The SCLK half-period is set by a parameter counted in system clocks.

Top module: `spi_uart_link`

## Requirements
- R1: A frame is 16 SCLK pulses sent MSB first, with cs_no held low for the whole frame; SCLK rests low whenever cs_no is high.
- R2: MOSI changes only while SCLK is low, and MISO is captured at each rising SCLK edge.
- R3: The first frame after reset is the configuration write {0xE4, BAUD_CODE}.
- R4: Each configuration write is followed by the read-back frame 0x4000. When the returned low byte differs from BAUD_CODE, the write and the read-back are repeated. When it matches, init_done_o rises and stays high, and no further configuration frames are sent.
- R5: A byte is taken when tx_valid_i and tx_ready_o are both high in the same cycle. It is sent as the frame {0x80 | (rts_en_i << 1), byte}, with rts_en_i sampled in that same cycle.
- R6: A receive uses the frame 0x0000. The low byte returned by the UART appears on rx_data_o while rx_valid_o is high for exactly one cycle.
- R7: cts_o takes bit 9 of the 16-bit word returned in each receive frame, which is bit 1 of its upper byte. cts_o holds that value until the next receive.
- R8: Each falling edge on irq_ni causes exactly one receive frame. A line that stays low causes no further frames.
- R9: tx_ready_o is low before init_done_o rises, while a frame is in progress, and while a receive is pending.
- R10: When a receive and a transmit are both pending, the receive frame goes first.
- R11: SCLK stays high for HALF_DIV clocks per pulse. cs_no stays high for at least HALF_DIV clocks between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Byte can be taken this cycle |
| rts_en_i | input | 1 | Request-to-send flag placed in transmit commands |
| irq_ni | input | 1 | UART interrupt, active low, acted on at its falling edge |
| miso_i | input | 1 | SPI data from the UART |
| cs_no | output | 1 | SPI chip select, active low |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to the UART |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| cts_o | output | 1 | Clear-to-send flag from the last receive |
| init_done_o | output | 1 | Configuration verified |

## Verification
A transmit request and an interrupt edge can both be waiting when the link returns to idle. Both are then eligible for the same launch cycle. The bench provokes this by dropping the interrupt line while a transmit frame is shifting, with a second byte already held on the valid/ready port. It judges the result from the order of frames seen on the SPI wires: the 0x0000 receive frame must come before the second transmit frame. It also checks that the received byte and cts_o carry the slave's answer, and that tx_ready_o stays low until the receive has been launched.

// File: rtl/spi_uart_pkg.sv
package spi_uart_pkg;
  localparam int FRAME_W = 16;
  localparam int BYTE_W  = 8;
  localparam int RTS_POS = 1;
  localparam int CTS_POS = BYTE_W + 1;

  localparam logic [BYTE_W-1:0] CMD_CFG_WR = 8'hE4;
  localparam logic [BYTE_W-1:0] CMD_CFG_RD = 8'h40;
  localparam logic [BYTE_W-1:0] CMD_TX     = 8'h80;

  typedef enum logic [1:0] {OP_CFG_WR, OP_CFG_RD, OP_TX, OP_RX} op_e;
  typedef enum logic [1:0] {SEQ_LAUNCH, SEQ_WAIT, SEQ_RUN} seq_st_e;
  typedef enum logic [1:0] {SH_IDLE, SH_LO, SH_HI, SH_GAP} sh_st_e;
endpackage

// File: rtl/irq_fall_detect.sv
module irq_fall_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_ni,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], irq_ni};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_uart_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_frame_o,
  output logic               cs_no,
  output logic               sclk_o,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  sh_st_e             st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] tx_sh_q, rx_sh_q;
  logic               half_end;

  assign half_end = (cnt_q == CNT_LAST);
  assign mosi_o   = tx_sh_q[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SH_IDLE;
      cnt_q      <= '0;
      bit_q      <= '0;
      tx_sh_q    <= '0;
      rx_sh_q    <= '0;
      rx_frame_o <= '0;
      cs_no      <= 1'b1;
      sclk_o     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        SH_IDLE: if (start_i) begin
          tx_sh_q <= frame_i;
          bit_q   <= '0;
          cnt_q   <= '0;
          cs_no   <= 1'b0;
          st_q    <= SH_LO;
        end
        SH_LO: begin
          if (half_end) begin
            cnt_q   <= '0;
            sclk_o  <= 1'b1;
            rx_sh_q <= {rx_sh_q[FRAME_W-2:0], miso_i};
            st_q    <= SH_HI;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SH_HI: begin
          if (half_end) begin
            cnt_q  <= '0;
            sclk_o <= 1'b0;
            if (bit_q == BIT_LAST) begin
              cs_no <= 1'b1;
              st_q  <= SH_GAP;
            end else begin
              tx_sh_q <= {tx_sh_q[FRAME_W-2:0], 1'b0};
              bit_q   <= bit_q + 1'b1;
              st_q    <= SH_LO;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (half_end) begin
            cnt_q      <= '0;
            done_o     <= 1'b1;
            rx_frame_o <= rx_sh_q;
            st_q       <= SH_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_link_seq.sv
module uart_link_seq
  import spi_uart_pkg::*;
#(
  parameter logic [BYTE_W-1:0] BAUD_CODE = 8'h0A
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               irq_fall_i,
  input  logic [BYTE_W-1:0]  tx_data_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  input  logic               rts_en_i,
  input  logic               sh_done_i,
  input  logic [FRAME_W-1:0] sh_rx_i,
  output logic               start_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [BYTE_W-1:0]  rx_data_o,
  output logic               rx_valid_o,
  output logic               cts_o,
  output logic               init_done_o
);
  localparam logic [FRAME_W-1:0] CFG_WR_FRAME = {CMD_CFG_WR, BAUD_CODE};
  localparam logic [FRAME_W-1:0] CFG_RD_FRAME = {CMD_CFG_RD, {BYTE_W{1'b0}}};

  seq_st_e st_q;
  op_e     op_q;
  logic    pend_q, pend_clr;
  logic [BYTE_W-1:0] tx_cmd;

  assign start_o    = (st_q == SEQ_LAUNCH);
  assign pend_clr   = (st_q == SEQ_RUN) && pend_q;
  assign tx_ready_o = (st_q == SEQ_RUN) && !pend_q;
  assign tx_cmd     = CMD_TX | (BYTE_W'(rts_en_i) << RTS_POS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SEQ_LAUNCH;
      op_q        <= OP_CFG_WR;
      frame_o     <= CFG_WR_FRAME;
      pend_q      <= 1'b0;
      rx_data_o   <= '0;
      rx_valid_o  <= 1'b0;
      cts_o       <= 1'b0;
      init_done_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      // a new edge in the clearing cycle stays pending
      pend_q     <= (pend_q & ~pend_clr) | irq_fall_i;
      case (st_q)
        SEQ_LAUNCH: st_q <= SEQ_WAIT;
        SEQ_WAIT: if (sh_done_i) begin
          case (op_q)
            OP_CFG_WR: begin
              frame_o <= CFG_RD_FRAME;
              op_q    <= OP_CFG_RD;
              st_q    <= SEQ_LAUNCH;
            end
            OP_CFG_RD: begin
              if (sh_rx_i[BYTE_W-1:0] == BAUD_CODE) begin
                init_done_o <= 1'b1;
                st_q        <= SEQ_RUN;
              end else begin
                frame_o <= CFG_WR_FRAME;
                op_q    <= OP_CFG_WR;
                st_q    <= SEQ_LAUNCH;
              end
            end
            OP_RX: begin
              rx_data_o  <= sh_rx_i[BYTE_W-1:0];
              cts_o      <= sh_rx_i[CTS_POS];
              rx_valid_o <= 1'b1;
              st_q       <= SEQ_RUN;
            end
            default: st_q <= SEQ_RUN;
          endcase
        end
        default: begin
          if (pend_q) begin
            frame_o <= '0;
            op_q    <= OP_RX;
            st_q    <= SEQ_LAUNCH;
          end else if (tx_valid_i) begin
            frame_o <= {tx_cmd, tx_data_i};
            op_q    <= OP_TX;
            st_q    <= SEQ_LAUNCH;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_uart_link.sv
module spi_uart_link
  import spi_uart_pkg::*;
#(
  parameter int          HALF_DIV  = 2,
  parameter logic [7:0]  BAUD_CODE = 8'h0A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  input  logic       rts_en_i,
  input  logic       irq_ni,
  input  logic       miso_i,
  output logic       cs_no,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  output logic       cts_o,
  output logic       init_done_o
);
  logic               irq_fall, sh_start, sh_done;
  logic [FRAME_W-1:0] sh_frame, sh_rx;

  irq_fall_detect #(.SYNC_STAGES(2)) u_irq (
    .clk_i (clk_i), .rst_ni(rst_ni), .irq_ni(irq_ni), .fall_o(irq_fall)
  );

  uart_link_seq #(.BAUD_CODE(BAUD_CODE)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_fall_i (irq_fall),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .rts_en_i   (rts_en_i),
    .sh_done_i  (sh_done),
    .sh_rx_i    (sh_rx),
    .start_o    (sh_start),
    .frame_o    (sh_frame),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .cts_o      (cts_o),
    .init_done_o(init_done_o)
  );

  spi_frame_shifter #(.HALF_DIV(HALF_DIV)) u_sh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (sh_start),
    .frame_i   (sh_frame),
    .done_o    (sh_done),
    .rx_frame_o(sh_rx),
    .cs_no     (cs_no),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o),
    .miso_i    (miso_i)
  );
endmodule

// File: rtl/spi_uart_link_chk.sv
module spi_uart_link_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_ready_o,
  input logic cs_no,
  input logic sclk_o,
  input logic mosi_o,
  input logic rx_valid_o,
  input logic cts_o,
  input logic init_done_o
);
  a_r1_sclk_rests_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r2_mosi_steady_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));
  a_r4_init_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  a_r6_rx_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  a_r7_cts_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(cts_o));
  a_r9_ready_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (cs_no && init_done_o));
  a_r11_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);
endmodule

bind spi_uart_link spi_uart_link_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_ready_o (tx_ready_o),
  .cs_no      (cs_no),
  .sclk_o     (sclk_o),
  .mosi_o     (mosi_o),
  .rx_valid_o (rx_valid_o),
  .cts_o      (cts_o),
  .init_done_o(init_done_o)
);

// File: tb/spi_uart_link_tb_top.sv
module spi_uart_link_tb_top;
  localparam int         HALF = 3;
  localparam logic [7:0] BAUD = 8'h3B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, rts_en = 1'b0, irq_n = 1'b1, miso = 1'b0;
  logic tx_ready, cs_n, sclk, mosi, rx_valid, cts, init_done;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  spi_uart_link #(.HALF_DIV(HALF), .BAUD_CODE(BAUD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rts_en_i(rts_en), .irq_ni(irq_n), .miso_i(miso),
    .cs_no(cs_n), .sclk_o(sclk), .mosi_o(mosi), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .cts_o(cts), .init_done_o(init_done)
  );

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural UART slave and wire-level model, evaluated on every falling clock
  logic [15:0] got_q[$];
  logic [15:0] resp_word = 16'h0000, cur_resp = 16'h0000, shin = 16'h0000;
  int frame_idx = 0, bitn = 0, rises = 0, hi_len = 0, gap_len = 0;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0;
  int rx_cnt = 0;
  logic [7:0] last_rx = '0;
  logic last_cts = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cs && !cs_n) begin
        if (frame_idx > 0) chk(gap_len >= HALF, "R11 cs gap", 16'(gap_len), 16'(HALF));
        cur_resp = (frame_idx < 3) ? 16'h0055 : resp_word;
        bitn = 15; rises = 0; shin = '0;
        miso = cur_resp[15];
      end
      if (!cs_n && sclk && !p_sclk) begin
        shin = {shin[14:0], mosi};
        rises++; hi_len = 0;
      end
      if (sclk) hi_len++;
      if (!cs_n && !sclk && p_sclk) begin
        chk(hi_len == HALF, "R11 sclk high time", 16'(hi_len), 16'(HALF));
        if (bitn > 0) begin bitn--; miso = cur_resp[bitn]; end
      end
      if (sclk && p_sclk && mosi !== p_mosi) chk(0, "R2 mosi moved with sclk high", 16'(mosi), 16'(p_mosi));
      if (cs_n && sclk) chk(0, "R1 sclk high while deselected", 16'(sclk), 16'd0);
      if (tx_ready && !cs_n) chk(0, "R9 ready during frame", 16'(tx_ready), 16'd0);
      if (!p_cs && cs_n) begin
        chk(rises == 16, "R1 sclk pulses per frame", 16'(rises), 16'd16);
        got_q.push_back(shin);
        frame_idx++; gap_len = 0;
      end
      if (cs_n) gap_len++;
      if (rx_valid) begin rx_cnt++; last_rx = rx_data; last_cts = cts; end
      p_cs = cs_n; p_sclk = sclk; p_mosi = mosi;
    end
  end

  task automatic expect_frame(input logic [15:0] exp, input string tag);
    logic [15:0] f;
    while (got_q.size() == 0) @(negedge clk);
    f = got_q.pop_front();
    chk(f == exp, tag, f, exp);
  endtask

  task automatic send(input logic [7:0] d, input logic r);
    @(negedge clk);
    tx_data = d; rts_en = r; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    while (rx_cnt < n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 16'd0, 16'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 reset idle bus", {14'd0, cs_n, sclk}, 16'h0002);
    chk(init_done == 1'b0, "R4 init_done low in reset", 16'(init_done), 16'd0);
    chk(tx_ready == 1'b0 && rx_valid == 1'b0, "R9 ready low in reset", {14'd0, tx_ready, rx_valid}, 16'd0);
    rst_n = 1'b1;

    // first read-back returns 0x55, second returns the baud code
    resp_word = {8'h00, BAUD};
    expect_frame({8'hE4, BAUD}, "R3 first config write");
    chk(init_done == 1'b0 && tx_ready == 1'b0, "R9 ready low before init", {14'd0, init_done, tx_ready}, 16'd0);
    expect_frame(16'h4000, "R4 read-back frame");
    expect_frame({8'hE4, BAUD}, "R4 retried config write");
    expect_frame(16'h4000, "R4 second read-back");
    repeat (10) @(negedge clk);
    chk(init_done == 1'b1, "R4 init_done after match", 16'(init_done), 16'd1);
    repeat (60) @(negedge clk);
    chk(got_q.size() == 0, "R4 no config frames after init", 16'(got_q.size()), 16'd0);

    send(8'hA5, 1'b0);
    expect_frame(16'h80A5, "R5 transmit rts off");
    send(8'h3C, 1'b1);
    expect_frame(16'h823C, "R5 transmit rts on");

    resp_word = 16'h0207;
    @(negedge clk) irq_n = 1'b0;
    expect_frame(16'h0000, "R6 receive frame");
    wait_rx(1);
    chk(last_rx == 8'h07, "R6 received byte", 16'(last_rx), 16'h0007);
    chk(last_cts == 1'b1, "R7 cts set", 16'(last_cts), 16'd1);
    repeat (120) @(negedge clk);
    chk(got_q.size() == 0 && rx_cnt == 1, "R8 held-low irq gives one receive", 16'(rx_cnt), 16'd1);
    irq_n = 1'b1;
    repeat (5) @(negedge clk);

    resp_word = 16'h00C4;
    irq_n = 1'b0;
    expect_frame(16'h0000, "R6 second receive frame");
    wait_rx(2);
    chk(last_rx == 8'hC4, "R6 second byte", 16'(last_rx), 16'h00C4);
    chk(cts == 1'b0, "R7 cts cleared", 16'(cts), 16'd0);
    irq_n = 1'b1;
    repeat (5) @(negedge clk);

    // receive and transmit both pending at the end of a transmit frame
    resp_word = 16'h0299;
    send(8'h11, 1'b0);
    tx_data = 8'h22; tx_valid = 1'b1; rts_en = 1'b0;
    repeat (4) @(negedge clk);
    irq_n = 1'b0;
    while (cs_n == 1'b0) @(negedge clk);
    while (!tx_ready) @(negedge clk);
    chk(rx_cnt == 3 || got_q.size() >= 2, "R10 receive launched before ready", 16'(rx_cnt), 16'd3);
    @(negedge clk) tx_valid = 1'b0;
    expect_frame(16'h8011, "R5 first queued transmit");
    expect_frame(16'h0000, "R10 receive goes first");
    expect_frame(16'h8022, "R10 transmit after receive");
    wait_rx(3);
    chk(last_rx == 8'h99, "R6 third byte", 16'(last_rx), 16'h0099);
    chk(cts == 1'b1, "R7 cts after third receive", 16'(cts), 16'd1);
    irq_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(cts == 1'b1 && rx_cnt == 3, "R7 cts held across transmit", 16'(cts), 16'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule